// File: doc/BRIEF.md
# Dual-Direction Transfer Register with Per-Path Latch, Clock and Enable Control

This block moves a data word between two ports, A and B, over two paths that do not depend on each other: one carries A toward B and the other carries B toward A. Each path has one storage register and four controls. These are an active-low drive enable, an active-high pass (transparent) enable, a transfer clock and an active-low clock enable. With the four controls a path can act as a plain buffer, a latch, an edge-triggered register or an edge-triggered register with a clock enable. The two paths may be enabled at the same moment.

The block runs on a fast system clock. The four controls of each path pass through a synchronizer chain. A rising edge on a path's transfer clock is found by comparing the newest synchronized sample with the one before it. Each port is shown as three separate vectors: incoming data, outgoing data and a per-bit drive-enable. Outside the block these can be joined into a tri-state pad. A drive-enable of zero means that port is in high impedance.

A change on any control takes effect three system-clock edges after it is driven. A change on a drive enable takes effect after two edges. The data input is not synchronized. It must stay stable while a transfer-clock edge travels through the synchronizer, which takes three system clocks.

Top module: `duplex_xfer_reg`

## Requirements
- R1: Each path carries a full WIDTH-bit word, with WIDTH = 18 by default. All bits reach the output independently, including all-ones and all-zeros words.
- R2: While a path's pass enable is 1, its output follows its input. A change on the input shows up at the output within four system clocks.
- R3: If the pass enable is 0, the clock enable (active low) is 0 and the transfer clock does not rise, the path's output keeps its stored word whatever its input does.
- R4: If the pass enable is 0 and the clock enable is 0, a 0-to-1 transition of the transfer clock stores the input word, which must be stable for three system clocks. That word then appears on the output.
- R5: While the clock enable is 1 and the pass enable is 0, edges on the transfer clock are ignored and the stored word stays the same.
- R6: The drive enable is active low. Value 0 sets every bit of that port's drive-enable vector to 1. Value 1 sets every bit to 0, which is high impedance.
- R7: The B-to-A path works exactly like the A-to-B path using its own four controls. Activity on one path never changes the other path's output, and both paths may drive at the same time.
- R8: When the pass enable falls, the path keeps the last word it saw while it was transparent.
- R9: A synchronous active-high reset clears both stored words to 0 and both drive-enable vectors to 0. It also clears the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | 18 | Word arriving on port A (source of the A-to-B path) |
| bIn | input | 18 | Word arriving on port B (source of the B-to-A path) |
| aOut | output | 18 | Word driven onto port A by the B-to-A path |
| aOutEn | output | 18 | Per-bit drive enable of port A, 0 = high impedance |
| bOut | output | 18 | Word driven onto port B by the A-to-B path |
| bOutEn | output | 18 | Per-bit drive enable of port B, 0 = high impedance |
| abDriveN | input | 1 | A-to-B drive enable, active low |
| abPassEn | input | 1 | A-to-B transparent enable, active high |
| abXferClk | input | 1 | A-to-B transfer clock, rising edge captures |
| abClkEnN | input | 1 | A-to-B clock enable, active low |
| baDriveN | input | 1 | B-to-A drive enable, active low |
| baPassEn | input | 1 | B-to-A transparent enable, active high |
| baXferClk | input | 1 | B-to-A transfer clock, rising edge captures |
| baClkEnN | input | 1 | B-to-A clock enable, active low |

## Verification
Each path's output is its storage register, so a wrong load decision shows up at once at the output. A missed edge, a spurious capture, or a capture while the clock enable is off shows a wrong word on the output port one clock after the wrong load. The word stays wrong until the next legal load. A fault in the synchronizer or the edge history makes a capture happen twice, early or not at all. The bench finds this by changing the input after each action and checking the output several clocks later. A wrong drive enable shows within two clocks on the drive-enable vector. A fault that couples the two paths shows as the idle path's output leaving its known value.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Strobes sent from the control slice to the datapath slice of one path
  typedef struct packed {
    logic load;      // write the input word into storage on this clock
    logic edgeLoad;  // the load is caused by a transfer-clock rising edge
    logic drive;     // the port outputs are enabled
  } xferStrobe_t;

  // Bit positions inside a path's synchronized control vector
  localparam int CTL_CLKEN_N = 0;
  localparam int CTL_XCLK    = 1;
  localparam int CTL_PASS    = 2;
  localparam int CTL_DRIVE_N = 3;
  localparam int CTL_COUNT   = 4;

  // Value after reset: outputs off, everything else low
  localparam logic [CTL_COUNT-1:0] CTL_RESET = 4'b1000;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        driveN,
  input  logic        passEn,
  input  logic        xferClk,
  input  logic        clkEnN,
  output xferStrobe_t stb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [CTL_COUNT-1:0] rawCtl;
  logic [SYNC_STAGES-1:0][CTL_COUNT-1:0] chain;
  logic [CTL_COUNT-1:0] syncCtl;
  logic prevClk;

  assign rawCtl[CTL_CLKEN_N] = clkEnN;
  assign rawCtl[CTL_XCLK]    = xferClk;
  assign rawCtl[CTL_PASS]    = passEn;
  assign rawCtl[CTL_DRIVE_N] = driveN;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain <= {SYNC_STAGES{CTL_RESET}};
        else     chain <= {chain[SYNC_STAGES-2:0], rawCtl};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= CTL_RESET;
        else     chain <= rawCtl;
      end
    end
  endgenerate

  assign syncCtl = chain[LAST];

  // Edge history: the transfer clock level from the previous system clock
  always_ff @(posedge clk) begin
    if (rst) prevClk <= 1'b0;
    else     prevClk <= syncCtl[CTL_XCLK];
  end

  logic risingXfer;
  assign risingXfer = syncCtl[CTL_XCLK] & ~prevClk;

  always_comb begin
    stb.edgeLoad = risingXfer & ~syncCtl[CTL_CLKEN_N] & ~syncCtl[CTL_PASS];
    stb.load     = syncCtl[CTL_PASS] | stb.edgeLoad;
    stb.drive    = ~syncCtl[CTL_DRIVE_N];
  end

  // A rising edge cannot be seen on two clocks in a row
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stb.edgeLoad |=> !stb.edgeLoad); // R4

  // With the clock enable off and the path not transparent, nothing loads
  AST_CLKEN_GATES: assert property (@(posedge clk) disable iff (rst)
    (syncCtl[CTL_CLKEN_N] && !syncCtl[CTL_PASS]) |-> !stb.load); // R5

endmodule

// File: rtl/xfer_data.sv
module xfer_data
  import xfer_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  xferStrobe_t      stb,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut,
  output logic [WIDTH-1:0] outEn
);

  logic [WIDTH-1:0] store;

  always_ff @(posedge clk) begin
    if (rst)           store <= '0;
    else if (stb.load) store <= dIn;
  end

  assign dOut  = store;
  assign outEn = {WIDTH{stb.drive}};

  // A load strobe puts the input word into storage
  AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> (store == $past(dIn))); // R2

  // Without a load strobe the stored word does not move
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> $stable(store)); // R3

  // The drive-enable vector is always all ones or all zeros
  AST_EN_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (outEn == '0) || (outEn == '1)); // R6

endmodule

// File: rtl/duplex_xfer_reg.sv
module duplex_xfer_reg
  import xfer_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOutEn,
  input  logic             abDriveN,
  input  logic             abPassEn,
  input  logic             abXferClk,
  input  logic             abClkEnN,
  input  logic             baDriveN,
  input  logic             baPassEn,
  input  logic             baXferClk,
  input  logic             baClkEnN
);

  localparam int PATHS = 2;  // lane 0: A to B, lane 1: B to A

  logic [PATHS-1:0][WIDTH-1:0] laneIn, laneOut, laneEn;
  logic [PATHS-1:0] laneDriveN, lanePass, laneClk, laneClkEnN;
  xferStrobe_t laneStb [PATHS];

  assign laneIn[0]     = aIn;
  assign laneIn[1]     = bIn;
  assign laneDriveN    = {baDriveN, abDriveN};
  assign lanePass      = {baPassEn, abPassEn};
  assign laneClk       = {baXferClk, abXferClk};
  assign laneClkEnN    = {baClkEnN, abClkEnN};

  assign bOut   = laneOut[0];
  assign bOutEn = laneEn[0];
  assign aOut   = laneOut[1];
  assign aOutEn = laneEn[1];

  generate
    for (genvar p = 0; p < PATHS; p++) begin : g_lane
      xfer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .driveN  (laneDriveN[p]),
        .passEn  (lanePass[p]),
        .xferClk (laneClk[p]),
        .clkEnN  (laneClkEnN[p]),
        .stb     (laneStb[p])
      );

      xfer_data #(.WIDTH(WIDTH)) i_data (
        .clk   (clk),
        .rst   (rst),
        .stb   (laneStb[p]),
        .dIn   (laneIn[p]),
        .dOut  (laneOut[p]),
        .outEn (laneEn[p])
      );
    end
  endgenerate

endmodule

// File: tb/test_duplex_xfer_reg.sv
`timescale 1ns/1ps
module test_duplex_xfer_reg;

  localparam int W = 18;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOutEn, bOut, bOutEn;
  logic abDriveN = 1'b1, abPassEn = 1'b0, abXferClk = 1'b0, abClkEnN = 1'b1;
  logic baDriveN = 1'b1, baPassEn = 1'b0, baXferClk = 1'b0, baClkEnN = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] lastExp [2];

  always #2.5 clk = ~clk;

  duplex_xfer_reg i_duplex_xfer_reg (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOutEn(aOutEn), .bOut(bOut), .bOutEn(bOutEn),
    .abDriveN(abDriveN), .abPassEn(abPassEn), .abXferClk(abXferClk), .abClkEnN(abClkEnN),
    .baDriveN(baDriveN), .baPassEn(baPassEn), .baXferClk(baXferClk), .baClkEnN(baClkEnN)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLane(input int d, input logic oeN, input logic le,
                         input logic ceN, input logic ck);
    if (d == 0) begin
      abDriveN = oeN; abPassEn = le; abClkEnN = ceN; abXferClk = ck;
    end else begin
      baDriveN = oeN; baPassEn = le; baClkEnN = ceN; baXferClk = ck;
    end
  endtask

  task automatic setData(input int d, input logic [W-1:0] v);
    if (d == 0) aIn = v; else bIn = v;
  endtask

  function automatic logic [W-1:0] laneOut(input int d);
    return (d == 0) ? bOut : aOut;
  endfunction

  function automatic logic [W-1:0] laneEn(input int d);
    return (d == 0) ? bOutEn : aOutEn;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    lastExp[0] = '0;
    lastExp[1] = '0;
    waitN(4);
    rst = 1'b0;
    waitN(4);
    // R9: cleared after reset
    chk("R9 reset bOut", bOut, '0);
    chk("R9 reset aOut", aOut, '0);
    chk("R9 reset bOutEn", bOutEn, '0);
    chk("R9 reset aOutEn", aOutEn, '0);

    // Sweep every combination of pass enable, clock enable and edge on both paths
    for (int d = 0; d < 2; d++) begin
      for (int idx = 0; idx < 8; idx++) begin
        logic le, ceN, edgeOn;
        logic [W-1:0] s0, s1, s2, exp;
        string tag;
        le = idx[2]; ceN = idx[1]; edgeOn = idx[0];
        s0 = 18'h15A3C ^ (18'(idx) * 18'h0731) ^ (18'(d) * 18'h2E05);
        s1 = ~s0;
        s2 = s0 ^ 18'h0F0F0;
        setLane(d, 1'b0, 1'b1, 1'b0, 1'b0);
        setData(d, s0);
        waitN(6);
        setLane(d, 1'b0, le, ceN, 1'b0);
        waitN(6);
        if (!le) chk("R8 keeps last transparent word", laneOut(d), s0);
        setData(d, s1);
        waitN(6);
        if (edgeOn) begin
          setLane(d, 1'b0, le, ceN, 1'b1);
          waitN(6);
          setLane(d, 1'b0, le, ceN, 1'b0);
          waitN(6);
        end
        if (le)                exp = s1;
        else if (edgeOn && !ceN) exp = s1;
        else                   exp = s0;
        if (le)                tag = "R2 transparent";
        else if (edgeOn && !ceN) tag = "R4 edge capture";
        else if (edgeOn)       tag = "R5 edge ignored";
        else                   tag = "R3 static hold";
        chk(tag, laneOut(d), exp);
        if (!le) begin
          setData(d, s2);
          waitN(6);
          chk("R3 hold against input change", laneOut(d), exp);
        end
        lastExp[d] = laneOut(d);
        if (le) lastExp[d] = (!le) ? exp : laneOut(d);
        // R7: idle path untouched
        chk("R7 other path unchanged", laneOut(1 - d), lastExp[1 - d]);
      end
      // park this path: not transparent, clock disabled
      setLane(d, 1'b0, 1'b0, 1'b1, 1'b0);
      waitN(6);
      lastExp[d] = laneOut(d);
    end

    // R6: drive enable polarity on each port
    for (int d = 0; d < 2; d++) begin
      setLane(d, 1'b1, 1'b0, 1'b1, 1'b0);
      waitN(4);
      chk("R6 high impedance", laneEn(d), '0);
      setLane(d, 1'b0, 1'b0, 1'b1, 1'b0);
      waitN(4);
      chk("R6 driving", laneEn(d), ALL1);
    end

    // R7 and R1: both paths transparent and driving at once, full-width words
    setLane(0, 1'b0, 1'b1, 1'b0, 1'b0);
    setLane(1, 1'b0, 1'b1, 1'b0, 1'b0);
    aIn = ALL1; bIn = '0;
    waitN(6);
    chk("R1 all ones A to B", bOut, ALL1);
    chk("R1 all zeros B to A", aOut, '0);
    chk("R7 both driving B", bOutEn, ALL1);
    chk("R7 both driving A", aOutEn, ALL1);
    aIn = '0; bIn = ALL1;
    waitN(6);
    chk("R1 all zeros A to B", bOut, '0);
    chk("R1 all ones B to A", aOut, ALL1);

    // R4 on both paths in the same cycle
    aIn = 18'h12345; bIn = 18'h2ABCD;
    setLane(0, 1'b0, 1'b0, 1'b0, 1'b0);
    setLane(1, 1'b0, 1'b0, 1'b0, 1'b0);
    waitN(6);
    setLane(0, 1'b0, 1'b0, 1'b0, 1'b1);
    setLane(1, 1'b0, 1'b0, 1'b0, 1'b1);
    waitN(6);
    aIn = '0; bIn = '0;
    waitN(6);
    chk("R4 simultaneous capture B", bOut, 18'h12345);
    chk("R4 simultaneous capture A", aOut, 18'h2ABCD);

    // R9: reset in mid-run clears stored words and enables
    @(negedge clk) rst = 1'b1;
    waitN(2);
    chk("R9 mid reset bOut", bOut, '0);
    chk("R9 mid reset aOut", aOut, '0);
    chk("R9 mid reset aOutEn", aOutEn, '0);
    rst = 1'b0;
    waitN(2);

    done = 1'b1;
    finishRun();
  end

endmodule